// File: doc/BRIEF.md
# Bus-Master Ownership Latency Timer

This block sits beside the transaction sequencer of an agent that can act as master on a shared parallel bus. The arbiter gives each master its own request and grant pair. This timer caps how long the master may keep the bus after it wins it. A new ownership period starts when the master begins a transaction while its grant is asserted. At that point an 8-bit limit is copied from a configuration register into a down-counter. The counter then loses one per bus clock while a transaction is active, and it holds its value while no transaction runs.

When the counter reaches zero, the expired flag rises. Expiry by itself does not stop the master. A release request goes to the sequencer only once the arbiter has also withdrawn the grant. While the grant stays asserted, the master may keep transferring. When the release request is raised and no other agent is waiting for the bus, the block also raises a re-request output, so the master can claim the bus again at once.

A limit of zero makes the flag rise on the first cycle of ownership.

Top module: `own_latency_timer`

## Requirements
- R1: After reset, `expired`, `release_req` and `rerequest` are all 0.
- R2: An ownership start is a clock edge at which `xact_active` is 1, `bus_grant` is 1, and `xact_active` was 0 at the previous edge. An ownership start loads the counter with `cfg_limit`. If the limit is nonzero, the same edge clears `expired`. This also applies to a new start after an earlier expiry.
- R3: With a nonzero limit L and `xact_active` held at 1, `expired` is 0 for the first L-1 edges after the start edge and becomes 1 at the L-th edge.
- R4: While `xact_active` is 0 the counter holds its value. Idle cycles therefore delay expiry by exactly their number.
- R5: With `cfg_limit` = 0, `expired` is 1 right after the start edge.
- R6: `release_req` is 1 exactly when `expired`, `xact_active` and not `bus_grant` all hold. While the grant is asserted, no release is requested.
- R7: `rerequest` is 1 exactly when `release_req` is 1 and `others_waiting` is 0.
- R8: If `xact_active` rises while `bus_grant` is 0, the counter does not reload and `expired` does not clear.
- R9: A change of `cfg_limit` during an ownership period has no effect until the next ownership start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_limit | input | W (8) | Ownership limit in bus clocks, from the configuration register |
| bus_grant | input | 1 | This master's grant from the arbiter |
| xact_active | input | 1 | The sequencer has a transaction in progress |
| others_waiting | input | 1 | Another agent is requesting the bus |
| expired | output | 1 | The ownership limit has been used up |
| release_req | output | 1 | Asks the sequencer to give up the bus |
| rerequest | output | 1 | Lets the master claim the bus again at once |

## Verification
A counter that loads, decrements or holds wrongly shows up at the ports as the flag rising one or more cycles early or late. The bench sweeps every limit value and compares the edge at which expiry appears against the edge computed from the limit. A flag that fails to clear on reload shows up on the first cycle after a new start. The release and re-request outputs are combinational from the flag. A wrong gating term therefore appears in the same cycle as the grant or waiting input changes.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_LOAD = 2'd1,
    ST_DEC  = 2'd2
  } step_e;

  // Selects the counter action for one clock.
  function automatic step_e pick_step(input logic start, input logic active,
                                      input logic at_zero);
    if (start)                  return ST_LOAD;
    else if (active && !at_zero) return ST_DEC;
    else                        return ST_HOLD;
  endfunction
endpackage

// File: rtl/lt_own_detect.sv
module lt_own_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_grant,
  input  logic xact_active,
  output logic own_start
);
  logic active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= xact_active;
  end

  // A granted transaction that was not running last cycle begins ownership.
  assign own_start = xact_active && !active_q && bus_grant;
endmodule

// File: rtl/lt_countdown.sv
module lt_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         own_start,
  input  logic         xact_active,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count_q,
  output logic         expired_q
);
  import lt_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] dec_count(input logic [W-1:0] v);
    return v - ONE;
  endfunction

  function automatic logic hits_zero(input logic [W-1:0] v);
    return v == ONE;
  endfunction

  step_e step;
  assign step = pick_step(own_start, xact_active, count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      expired_q <= 1'b0;
    end else begin
      case (step)
        ST_LOAD: begin
          count_q   <= limit;
          expired_q <= (limit == '0);
        end
        ST_DEC: begin
          count_q <= dec_count(count_q);
          if (hits_zero(count_q)) expired_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lt_release.sv
module lt_release (
  input  logic expired,
  input  logic bus_grant,
  input  logic xact_active,
  input  logic others_waiting,
  output logic release_req,
  output logic rerequest
);
  assign release_req = expired && xact_active && !bus_grant;
  assign rerequest   = release_req && !others_waiting;
endmodule

// File: rtl/own_latency_timer.sv
module own_latency_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cfg_limit,
  input  logic         bus_grant,
  input  logic         xact_active,
  input  logic         others_waiting,
  output logic         expired,
  output logic         release_req,
  output logic         rerequest
);
  logic         own_start;
  logic [W-1:0] count_q;

  lt_own_detect u_detect (
    .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant),
    .xact_active(xact_active), .own_start(own_start)
  );

  lt_countdown #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .own_start(own_start),
    .xact_active(xact_active), .limit(cfg_limit),
    .count_q(count_q), .expired_q(expired)
  );

  lt_release u_rel (
    .expired(expired), .bus_grant(bus_grant), .xact_active(xact_active),
    .others_waiting(others_waiting), .release_req(release_req),
    .rerequest(rerequest)
  );
endmodule

// File: rtl/own_latency_timer_chk.sv
module own_latency_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cfg_limit,
  input logic         bus_grant,
  input logic         xact_active,
  input logic         others_waiting,
  input logic         expired,
  input logic         release_req,
  input logic         rerequest,
  input logic         own_start,
  input logic [W-1:0] count_q
);
  AST_LOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    own_start |=> count_q == $past(cfg_limit)); // R2

  AST_CLEAR_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (own_start && cfg_limit != '0) |=> !expired); // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_active && !own_start && count_q != '0) |=> count_q == $past(count_q) - 1'b1); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xact_active |=> $stable(count_q) && $stable(expired)); // R4

  AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (own_start && cfg_limit == '0) |=> expired); // R5

  AST_EXPIRED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> count_q == '0); // R3

  AST_NO_RELEASE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> !release_req); // R6

  AST_REREQ_ONLY_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    rerequest |-> (release_req && !others_waiting)); // R7

  AST_NO_UNGRANTED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant && expired) |=> expired); // R8
endmodule

bind own_latency_timer own_latency_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit), .bus_grant(bus_grant),
  .xact_active(xact_active), .others_waiting(others_waiting),
  .expired(expired), .release_req(release_req), .rerequest(rerequest),
  .own_start(own_start), .count_q(count_q)
);

// File: tb/own_latency_timer_tb_top.sv
module own_latency_timer_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cfg_limit = '0;
  logic         bus_grant = 1'b0;
  logic         xact_active = 1'b0;
  logic         others_waiting = 1'b0;
  logic         expired, release_req, rerequest;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  own_latency_timer #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit), .bus_grant(bus_grant),
    .xact_active(xact_active), .others_waiting(others_waiting),
    .expired(expired), .release_req(release_req), .rerequest(rerequest)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    xact_active = 1'b0; bus_grant = 1'b0; others_waiting = 1'b0;
    tick(); tick();
  endtask

  // Start ownership with limit L and run until one edge past expiry.
  task automatic run_limit(input int lim);
    cfg_limit = W'(lim); bus_grant = 1'b1; xact_active = 1'b1;
    tick();
    check(lim == 0 ? "R5" : "R2", expired, lim == 0);
    for (int k = 1; k <= lim + 1; k++) begin
      tick();
      if (k == lim - 1 || k >= lim) check("R3", expired, k >= lim);
    end
    check("R6 granted", release_req, 1'b0);
    bus_grant = 1'b0; #1;
    check("R6 dropped", release_req, 1'b1);
    check("R7 alone", rerequest, 1'b1);
    others_waiting = 1'b1; #1;
    check("R7 contended", rerequest, 1'b0);
    go_idle();
  endtask

  initial begin
    tick(); tick();
    check("R1", expired, 1'b0);
    check("R1", release_req, 1'b0);
    check("R1", rerequest, 1'b0);
    rst_n = 1'b1;
    tick();

    for (int lim = 0; lim < 256; lim++) run_limit(lim);

    // R4: 3 active edges, 5 idle, resume without grant: expiry after 7 more.
    cfg_limit = 8'd10; bus_grant = 1'b1; xact_active = 1'b1;
    tick();
    bus_grant = 1'b0;
    for (int k = 0; k < 3; k++) tick();
    xact_active = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    check("R4 idle", expired, 1'b0);
    xact_active = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      tick();
      if (k >= 6) check("R4 resume", expired, k == 7);
    end

    // R8: ungranted restart keeps the flag and does not reload.
    xact_active = 1'b0; tick();
    xact_active = 1'b1; tick(); tick();
    check("R8", expired, 1'b1);
    check("R6 ungranted", release_req, 1'b1);
    go_idle();

    // R9: limit change mid-period is ignored.
    cfg_limit = 8'd4; bus_grant = 1'b1; xact_active = 1'b1;
    tick();
    cfg_limit = 8'd100;
    for (int k = 1; k <= 4; k++) begin
      tick();
      if (k >= 3) check("R9", expired, k == 4);
    end
    go_idle();

    // R2: reload after expiry clears the flag.
    cfg_limit = 8'd2; bus_grant = 1'b1; xact_active = 1'b1;
    tick();
    check("R2 reload", expired, 1'b0);
    go_idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule